// File: doc/BRIEF.md
# SPI Host Link Transaction Engine

This block is the host side of a byte-oriented SPI link to a radio controller. The controller raises a ready line when it wants service. The engine turns each service into one framed transaction. It selects the slave, sends a one-byte command, and clocks in a one-byte status that grants a payload length. It then moves that many payload bytes through a byte-level shifter handshake. Bytes that come back are kept in a local receive FIFO, which a consumer drains through a simple read port. Bytes to send are taken from an upstream byte stream, loaded as a remaining-length count. The engine sends them in chunks, as large as each status grant allows.

Between transactions the engine arbitrates. A receive is preferred when the controller is ready and the FIFO can take a whole chunk. Otherwise pending transmit data opens a write transaction, which waits for ready before it sends the command. Otherwise the engine stays idle and keeps sampling ready. Ready passes through a two-flop synchronizer before it is used.

Top module: `spi_link_engine`

## Requirements
- R1: After reset, cs_o, sh_req_o, tx_pop_o, tx_done_o and rx_ovf_o are 0, rx_empty_o is 1 and rx_count_o is 0.
- R2: A read transaction has a fixed byte order. First the command byte 0x81 goes out (sh_dir_o=1). Then exactly one status byte comes in (sh_dir_o=0). Then as many bytes come in as the status grants, and these are appended to the receive FIFO in arrival order.
- R3: A write transaction has a fixed byte order. First the command byte 0x42 goes out. Then one status byte comes in. Then min(status, bytes pending) bytes go out, each taken from tx_data_i and acknowledged with one tx_pop_o pulse. The pending count drops by the number of bytes sent.
- R4: A write status of 0 ends the transaction with no payload: cs_o is released and nothing is popped.
- R5: cs_o is high from before the command byte until after the last payload byte, and is low for at least one cycle between transactions. sh_req_o is only high while cs_o is high, and a requested byte is held until it is acknowledged.
- R6: Arbitration order when idle: (a) if ready is seen and the FIFO has at least 64 free entries, start a read; (b) else if transmit bytes are pending, start a write; (c) else start nothing. A ready level that is already high when the engine goes idle starts the next transaction.
- R7: tx_done_o pulses for one cycle, once, in the cycle after the pop that empties the pending count. It does not pulse after a partial chunk.
- R8: A read grant above 64 is clamped to 64 bytes, and rx_ovf_o is set and stays set until reset.
- R9: rx_data_o shows the oldest FIFO byte. rx_rd_i pops it when the FIFO is not empty. rx_count_o gives the fill level and never exceeds 128.
- R10: tx_load_i loads tx_len_i as the pending count only when the pending count is 0; a load while bytes are pending is ignored.
- R11: A read status of 0 ends the transaction after the status byte, with nothing appended to the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | 1 | Controller ready line, asynchronous |
| cs_o | output | 1 | Chip select to the controller, active high |
| sh_req_o | output | 1 | Byte transfer request to the shifter |
| sh_dir_o | output | 1 | 1: byte driven out, 0: byte clocked in |
| sh_wdata_o | output | 8 | Byte to shift out |
| sh_ack_i | input | 1 | Shifter completes the requested byte this cycle |
| sh_rdata_i | input | 8 | Byte shifted in, valid with sh_ack_i |
| tx_load_i | input | 1 | Load a new transmit length |
| tx_len_i | input | 16 | Transmit length in bytes |
| tx_data_i | input | 8 | Current byte of the transmit stream |
| tx_pop_o | output | 1 | Advance the transmit stream by one byte |
| tx_done_o | output | 1 | One-cycle pulse when the pending count reaches zero |
| rx_rd_i | input | 1 | Pop one byte from the receive FIFO |
| rx_data_o | output | 8 | Oldest byte in the receive FIFO |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_count_o | output | 8 | Receive FIFO fill level |
| rx_ovf_o | output | 1 | Sticky flag: a read grant was clamped |

## Verification
The engine reacts to ready three edges after the line changes: two synchronizer stages and one arbitration edge. Every byte moves on the edge where sh_req_o and sh_ack_i are both high. A pushed byte shows in rx_count_o right after that edge, and tx_done_o follows the final pop by one cycle. The bench's slave model logs each transfer at that edge. It waits for the falling edge of cs_o, and only at the next falling clock edge does it compare the log, the FIFO level, the pop count and the done count against values it worked out from the grants it issued. So every result is sampled after the last register on its path has settled.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h42;
  localparam logic [7:0] CMD_READ  = 8'h81;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT_RDY,
    SQ_CMD,
    SQ_STAT,
    SQ_DATA
  } seq_state_t;
endpackage

// File: rtl/spi_link_sync.sv
module spi_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], async_i};
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_link_fifo.sv
module spi_link_fifo #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data_i;
  end

  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/spi_link_seq.sv
module spi_link_seq
  import spi_link_pkg::*;
#(
  parameter int CHUNK_MAX = 64,
  parameter int TXLEN_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready_s_i,
  input  logic               rx_room_i,
  input  logic               tx_load_i,
  input  logic [TXLEN_W-1:0] tx_len_i,
  input  logic [7:0]         tx_data_i,
  input  logic               sh_ack_i,
  input  logic [7:0]         sh_rdata_i,
  output logic               cs_o,
  output logic               sh_req_o,
  output logic               sh_dir_o,
  output logic [7:0]         sh_wdata_o,
  output logic               rx_push_o,
  output logic               tx_pop_o,
  output logic               tx_done_o,
  output logic               rx_ovf_o
);
  localparam logic [7:0] CHUNK_B = 8'(CHUNK_MAX);

  seq_state_t         state_q, state_d;
  logic               is_rd_q, is_rd_d;
  logic [7:0]         left_q, left_d;
  logic [TXLEN_W-1:0] rem_q, rem_d;
  logic               ovf_q, ovf_d;
  logic               done_q, done_d;
  logic               xfer;

  assign sh_req_o = (state_q == SQ_CMD) || (state_q == SQ_STAT) || (state_q == SQ_DATA);
  assign xfer     = sh_req_o && sh_ack_i;

  always_comb begin
    state_d = state_q;
    is_rd_d = is_rd_q;
    left_d  = left_q;
    rem_d   = rem_q;
    ovf_d   = ovf_q;
    done_d  = 1'b0;
    if (tx_load_i && (rem_q == '0)) rem_d = tx_len_i;
    case (state_q)
      SQ_IDLE: begin
        if (ready_s_i && rx_room_i) begin
          state_d = SQ_CMD;
          is_rd_d = 1'b1;
        end else if (rem_q != '0) begin
          state_d = SQ_WAIT_RDY;
          is_rd_d = 1'b0;
        end
      end
      SQ_WAIT_RDY: if (ready_s_i) state_d = SQ_CMD;
      SQ_CMD:      if (xfer) state_d = SQ_STAT;
      SQ_STAT: begin
        if (xfer) begin
          state_d = (sh_rdata_i == 8'd0) ? SQ_IDLE : SQ_DATA;
          if (is_rd_q) begin
            if (sh_rdata_i > CHUNK_B) begin
              ovf_d  = 1'b1;
              left_d = CHUNK_B;
            end else begin
              left_d = sh_rdata_i;
            end
          end else begin
            left_d = (rem_q < TXLEN_W'(sh_rdata_i)) ? rem_q[7:0] : sh_rdata_i;
          end
        end
      end
      SQ_DATA: begin
        if (xfer) begin
          left_d = left_q - 1'b1;
          if (!is_rd_q) begin
            rem_d = rem_q - 1'b1;
            if (rem_q == TXLEN_W'(1)) done_d = 1'b1;
          end
          if (left_q == 8'd1) state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      is_rd_q <= 1'b0;
      left_q  <= '0;
      rem_q   <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      is_rd_q <= is_rd_d;
      left_q  <= left_d;
      rem_q   <= rem_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    sh_wdata_o = 8'h00;
    if (state_q == SQ_CMD)                    sh_wdata_o = is_rd_q ? CMD_READ : CMD_WRITE;
    else if (state_q == SQ_DATA && !is_rd_q)  sh_wdata_o = tx_data_i;
  end

  assign cs_o      = (state_q != SQ_IDLE);
  assign sh_dir_o  = (state_q == SQ_CMD) || ((state_q == SQ_DATA) && !is_rd_q);
  assign rx_push_o = xfer && (state_q == SQ_DATA) && is_rd_q;
  assign tx_pop_o  = xfer && (state_q == SQ_DATA) && !is_rd_q;
  assign tx_done_o = done_q;
  assign rx_ovf_o  = ovf_q;
endmodule

// File: rtl/spi_link_engine.sv
module spi_link_engine #(
  parameter int FIFO_DEPTH = 128,
  parameter int CHUNK_MAX  = 64,
  parameter int TXLEN_W    = 16,
  parameter int SYNC_STG   = 2,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready_i,
  output logic               cs_o,
  output logic               sh_req_o,
  output logic               sh_dir_o,
  output logic [7:0]         sh_wdata_o,
  input  logic               sh_ack_i,
  input  logic [7:0]         sh_rdata_i,
  input  logic               tx_load_i,
  input  logic [TXLEN_W-1:0] tx_len_i,
  input  logic [7:0]         tx_data_i,
  output logic               tx_pop_o,
  output logic               tx_done_o,
  input  logic               rx_rd_i,
  output logic [7:0]         rx_data_o,
  output logic               rx_empty_o,
  output logic [CW-1:0]      rx_count_o,
  output logic               rx_ovf_o
);
  logic          ready_s;
  logic          rx_push;
  logic          rx_room;
  logic [CW-1:0] rx_free;

  spi_link_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ready_i), .sync_o(ready_s)
  );

  spi_link_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(rx_push), .push_data_i(sh_rdata_i),
    .pop_i(rx_rd_i), .head_o(rx_data_o), .count_o(rx_count_o)
  );

  assign rx_free    = CW'(FIFO_DEPTH) - rx_count_o;
  assign rx_room    = rx_free >= CW'(CHUNK_MAX);
  assign rx_empty_o = (rx_count_o == '0);

  spi_link_seq #(.CHUNK_MAX(CHUNK_MAX), .TXLEN_W(TXLEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ready_s_i(ready_s), .rx_room_i(rx_room),
    .tx_load_i(tx_load_i), .tx_len_i(tx_len_i), .tx_data_i(tx_data_i),
    .sh_ack_i(sh_ack_i), .sh_rdata_i(sh_rdata_i),
    .cs_o(cs_o), .sh_req_o(sh_req_o), .sh_dir_o(sh_dir_o), .sh_wdata_o(sh_wdata_o),
    .rx_push_o(rx_push), .tx_pop_o(tx_pop_o), .tx_done_o(tx_done_o), .rx_ovf_o(rx_ovf_o)
  );
endmodule

// File: rtl/spi_link_engine_chk.sv
module spi_link_engine_chk #(
  parameter int FIFO_DEPTH = 128,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_o,
  input logic          sh_req_o,
  input logic          sh_dir_o,
  input logic [7:0]    sh_wdata_o,
  input logic          sh_ack_i,
  input logic          tx_pop_o,
  input logic          tx_done_o,
  input logic          rx_ovf_o,
  input logic [CW-1:0] rx_count_o
);
  a_r5_req_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req_o |-> cs_o);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_req_o && !sh_ack_i) |=> (sh_req_o && $stable(sh_dir_o) && $stable(sh_wdata_o)));

  a_r3_pop_is_sent_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |-> (sh_req_o && sh_ack_i && sh_dir_o));

  a_r7_done_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |-> $past(tx_pop_o));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |=> !tx_done_o);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_o |=> rx_ovf_o);

  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count_o <= CW'(FIFO_DEPTH));
endmodule

bind spi_link_engine spi_link_engine_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_o(cs_o), .sh_req_o(sh_req_o), .sh_dir_o(sh_dir_o),
  .sh_wdata_o(sh_wdata_o), .sh_ack_i(sh_ack_i), .tx_pop_o(tx_pop_o),
  .tx_done_o(tx_done_o), .rx_ovf_o(rx_ovf_o), .rx_count_o(rx_count_o)
);

// File: tb/tb_spi_link_engine.sv
`timescale 1ns/1ps
module tb_spi_link_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ready = 1'b0;
  logic        sh_req, sh_dir, sh_ack = 1'b0;
  logic [7:0]  sh_wdata, sh_rdata = 8'h00;
  logic        tx_load = 1'b0;
  logic [15:0] tx_len = '0;
  logic [7:0]  tx_data;
  logic        tx_pop, tx_done, cs;
  logic        rx_rd = 1'b0;
  logic [7:0]  rx_data, rx_count;
  logic        rx_empty, rx_ovf;

  always #4 clk = ~clk;

  spi_link_engine dut (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .cs_o(cs),
    .sh_req_o(sh_req), .sh_dir_o(sh_dir), .sh_wdata_o(sh_wdata),
    .sh_ack_i(sh_ack), .sh_rdata_i(sh_rdata),
    .tx_load_i(tx_load), .tx_len_i(tx_len), .tx_data_i(tx_data),
    .tx_pop_o(tx_pop), .tx_done_o(tx_done),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
    .rx_count_o(rx_count), .rx_ovf_o(rx_ovf)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // transmit stream, slave responses, transfer log, expected FIFO contents
  logic [7:0] txbuf [0:1023];
  int         tx_idx = 0;
  logic [7:0] resp [0:4095];
  int         resp_w = 0, resp_r = 0;
  logic       log_dir [0:8191];
  logic [7:0] log_b   [0:8191];
  int         log_n = 0;
  logic [7:0] exp_q [0:8191];
  int         exp_h = 0, exp_t = 0;
  int         txn_cnt = 0, done_cnt = 0;
  logic       cs_prev = 1'b0;
  int         raise_tok = 0, raise_seen = 0, lower_tok = 0, lower_seen = 0;
  int         cmd_total = 0, keep_upto = 0;
  logic       cmd_seen = 1'b0;
  int         dly = 2;

  assign tx_data = txbuf[tx_idx % 1024];

  // monitor: every byte moves on a posedge with req and ack high
  always @(posedge clk) begin
    cs_prev <= cs;
    if (cs_prev && !cs) txn_cnt <= txn_cnt + 1;
    if (tx_pop) tx_idx <= tx_idx + 1;
    if (tx_done) done_cnt <= done_cnt + 1;
    if (sh_req && sh_ack) begin
      log_dir[log_n] <= sh_dir;
      log_b[log_n]   <= sh_dir ? sh_wdata : sh_rdata;
      log_n          <= log_n + 1;
    end
  end

  // slave and shifter model, driven away from the active edge
  always @(negedge clk) begin
    if (!cs) cmd_seen <= 1'b0;
    if (raise_tok != raise_seen) begin
      ready <= 1'b1; raise_seen <= raise_tok;
    end else if (lower_tok != lower_seen) begin
      ready <= 1'b0; lower_seen <= lower_tok;
    end
    if (!sh_req || sh_ack) begin
      sh_ack <= 1'b0;
      dly    <= 2 + int'($urandom % 3);
    end else if (dly == 0) begin
      sh_ack <= 1'b1;
      if (!sh_dir) begin
        sh_rdata <= resp[resp_r % 4096];
        resp_r   <= resp_r + 1;
      end else if (!cmd_seen) begin
        cmd_seen  <= 1'b1;
        cmd_total <= cmd_total + 1;
        if (cmd_total + 1 > keep_upto) ready <= 1'b0;
      end
    end else begin
      dly <= dly - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_resp(input logic [7:0] b);
    resp[resp_w % 4096] = b;
    resp_w++;
  endtask

  task automatic raise_ready();
    @(negedge clk); raise_tok++;
  endtask

  task automatic lower_ready();
    @(negedge clk); lower_tok++;
  endtask

  task automatic wait_txn(input int target, input string tag);
    int t = 0;
    while (txn_cnt < target && t < 20000) begin
      @(negedge clk); t++;
    end
    chk(txn_cnt >= target, tag, txn_cnt, target);
    @(negedge clk);
  endtask

  task automatic load_tx(input int n);
    for (int k = 0; k < n; k++) txbuf[(tx_idx + k) % 1024] = 8'($urandom);
    @(negedge clk); tx_load = 1'b1; tx_len = 16'(n);
    @(negedge clk); tx_load = 1'b0;
  endtask

  // read transaction with a given grant; returns nothing, checks log order
  task automatic do_read(input int grant, input string tag);
    int s, n, bad;
    logic [7:0] b;
    @(negedge clk);
    s = log_n;
    n = (grant > 64) ? 64 : grant;
    push_resp(8'(grant));
    for (int k = 0; k < n; k++) begin
      b = 8'($urandom);
      push_resp(b);
      exp_q[exp_t % 8192] = b;
      exp_t++;
    end
    raise_ready();
    wait_txn(txn_cnt + 1, tag);
    chk(log_b[s] == 8'h81 && log_dir[s] == 1'b1, {tag, " read command 0x81"}, int'(log_b[s]), 'h81);
    chk(log_n - s == 2 + n, {tag, " read byte count"}, log_n - s, 2 + n);
    bad = 0;
    for (int k = 1; k < log_n - s; k++) if (log_dir[s + k] != 1'b0) bad++;
    chk(bad == 0, {tag, " read bytes clocked in"}, bad, 0);
  endtask

  // one write chunk; grant from slave, n bytes expected out
  task automatic do_write(input int grant, input int n, input string tag);
    int s, base, bad;
    @(negedge clk);
    s = log_n;
    base = tx_idx;
    push_resp(8'(grant));
    raise_ready();
    wait_txn(txn_cnt + 1, tag);
    chk(log_b[s] == 8'h42 && log_dir[s] == 1'b1, {tag, " write command 0x42"}, int'(log_b[s]), 'h42);
    chk(log_n - s == 2 + n, {tag, " write byte count"}, log_n - s, 2 + n);
    bad = 0;
    for (int k = 0; k < n && k + 2 < log_n - s; k++)
      if (log_b[s + 2 + k] != txbuf[(base + k) % 1024] || log_dir[s + 2 + k] != 1'b1) bad++;
    chk(bad == 0, {tag, " write payload matches stream"}, bad, 0);
    chk(tx_idx == base + n, {tag, " pops"}, tx_idx - base, n);
  endtask

  task automatic drain(input string tag);
    int bad = 0;
    @(negedge clk);
    chk(int'(rx_count) == exp_t - exp_h, {tag, " R9 fill level"}, int'(rx_count), exp_t - exp_h);
    while (!rx_empty) begin
      if (rx_data != exp_q[exp_h % 8192]) bad++;
      exp_h++;
      rx_rd = 1'b1;
      @(negedge clk);
    end
    rx_rd = 1'b0;
    chk(bad == 0 && exp_h == exp_t, {tag, " R9 FIFO order"}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0, base_done, rem, g, n;
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!cs && !sh_req && !tx_pop && !tx_done && !rx_ovf, "R1 outputs idle", int'(cs), 0);
    chk(rx_empty && rx_count == 0, "R1 FIFO empty", int'(rx_count), 0);

    // R2 read with grant 5, R9 drain
    do_read(5, "R2");
    drain("R2");

    // R11 read with zero grant
    s0 = log_n;
    do_read(0, "R11");
    chk(rx_count == 0, "R11 nothing appended", int'(rx_count), 0);

    // R3 write of 10 bytes, partial chunk of 4; R7 no done yet
    load_tx(10);
    do_write(4, 4, "R3");
    chk(done_cnt == 0, "R7 no done after partial chunk", done_cnt, 0);
    // R10 load while pending is ignored
    @(negedge clk); tx_load = 1'b1; tx_len = 16'd3;
    @(negedge clk); tx_load = 1'b0;
    // R4 zero write grant
    do_write(0, 0, "R4");
    chk(tx_idx == 4, "R4 nothing popped", tx_idx, 4);
    // R3 grant above pending sends only the rest
    do_write(200, 6, "R3 clip");
    chk(done_cnt == 1, "R7 done once at end", done_cnt, 1);
    s0 = log_n;
    repeat (40) @(negedge clk);
    chk(!cs && log_n == s0, "R10 ignored load left nothing pending", log_n - s0, 0);

    // R8 clamp and sticky overflow
    do_read(100, "R8");
    chk(rx_ovf == 1'b1, "R8 overflow set", int'(rx_ovf), 1);
    chk(rx_count == 64, "R8 clamped to 64", int'(rx_count), 64);
    drain("R8");
    chk(rx_ovf == 1'b1, "R8 overflow sticky", int'(rx_ovf), 1);

    // R6 read preferred when ready stays high at idle (R5 gap seen via txn count)
    load_tx(8);
    keep_upto = cmd_total + 1;
    push_resp(8'd2);
    push_resp(8'd3);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] b = 8'($urandom);
      push_resp(b); exp_q[exp_t % 8192] = b; exp_t++;
    end
    s0 = log_n;
    raise_ready();
    wait_txn(txn_cnt + 2, "R6 two transactions");
    chk(log_b[s0] == 8'h42, "R6 first is write", int'(log_b[s0]), 'h42);
    chk(log_b[s0 + 4] == 8'h81, "R6 read preferred at idle with ready high", int'(log_b[s0 + 4]), 'h81);
    keep_upto = 0;
    do_write(6, 6, "R6 rest");
    chk(done_cnt == 2, "R7 done count", done_cnt, 2);
    drain("R6");

    // R6 FIFO without room: write chosen although ready is high
    do_read(64, "R6 fill");
    do_read(10, "R6 fill2");
    load_tx(4);
    keep_upto = cmd_total + 1;
    push_resp(8'd2);
    push_resp(8'd2);
    s0 = log_n;
    raise_ready();
    wait_txn(txn_cnt + 2, "R6 full");
    chk(log_b[s0 + 4] == 8'h42, "R6 write when FIFO lacks room", int'(log_b[s0 + 4]), 'h42);
    chk(done_cnt == 3, "R7 done after second chunk", done_cnt, 3);
    keep_upto = 0;
    // R6 nothing to do: ready high, no room, nothing pending
    s0 = log_n;
    raise_ready();
    repeat (40) @(negedge clk);
    chk(!cs && log_n == s0, "R6 no transaction without room or data", log_n - s0, 0);
    lower_ready();
    drain("R6 full");

    // random mix of reads and writes
    for (int r = 0; r < 24; r++) begin
      if ($urandom % 2 == 0) begin
        do_read(int'($urandom % 65), "R2 random");
        drain("R2 random");
      end else begin
        rem = 1 + int'($urandom % 40);
        base_done = done_cnt;
        load_tx(rem);
        while (rem > 0) begin
          g = int'($urandom % 21);
          n = (g < rem) ? g : rem;
          do_write(g, n, "R3 random");
          rem -= n;
        end
        chk(done_cnt == base_done + 1, "R7 random done once", done_cnt - base_done, 1);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule